// File: doc/BRIEF.md
# Always-On Wakeup Interrupt Controller

This block collects up to 32 interrupt inputs in an always-on power domain and turns them into two requests. Input 0 is an external non-maskable interrupt pin: it is brought into the clock domain by a two-flop synchronizer, then a programmable trigger stage fires on a level or on an edge. Its pending bit, gated by its enable bit, goes to the main interrupt controller as a level-high request. Inputs 1 and up are level-high sources that are already synchronous to the block clock.

Every input sets a pending bit that software clears by writing ones. A second output, meant for a power-management coprocessor, is the OR of all pending bits that are neither masked nor held back by a response bit. A vector register returns a programmed base address plus four times the index of the lowest pending unmasked input. There is no priority arbitration and no fast-interrupt path.

Register access uses a small request/acknowledge bus that a two-state machine controls. In `BUS_IDLE`, a request is accepted and the machine takes the transition *accept* to `BUS_ACK`. In `BUS_ACK`, it returns the acknowledge and takes the transition *release* back to `BUS_IDLE`.

Top module: `aon_wake_intc`

## Requirements
- R1: After reset, the base, pending, enable, mask and response registers read 0, the trigger control reads 3 (rising edge), and both `nmi_req` and `cpu_irq` are low.
- R2: A request seen in `BUS_IDLE` is accepted at that clock edge. `bus_ack` is high for exactly the following cycle, with read data valid in that cycle. The offsets are: vector 0x00 (read-only), base 0x04, trigger control 0x0C (bits 1:0), pending 0x10, enable 0x40, mask 0x50 and response 0x60. Bit i of each 32-bit register belongs to input i.
- R3: The base register keeps write bits 31:2, and bits 1:0 read as 0.
- R4: The trigger control selects how the synchronized pin sets pending bit 0: 00 low level, 01 falling edge, 10 high level, 11 rising edge. The pin passes through two synchronizing flops before detection.
- R5: `nmi_req` is high exactly when pending bit 0 and enable bit 0 are both 1.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A level source that is still active sets the bit again on the next cycle. An edge event on input 0 in the same cycle as a clear still sets the bit.
- R7: `cpu_irq` is the OR over all inputs of pending AND NOT mask AND NOT response. The enable register has no effect on `cpu_irq`.
- R8: The vector reads base plus 4 times the lowest index whose pending bit is 1 and mask bit is 0. When there is no such index, it reads the base.
- R9: Reads of any other offset return 0. Writes to those offsets, and writes to the vector offset, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access complete, one cycle |
| nmi_pin | input | 1 | Asynchronous external NMI pin (input 0) |
| irq_src | input | N_IRQ-1 | Level-high sources for inputs 1 and up |
| nmi_req | output | 1 | Level-high NMI request to the main controller |
| cpu_irq | output | 1 | Request to the power-management coprocessor |

## Verification
The assertions assume that a master issues a new request only after the previous acknowledge, and that `irq_src` is synchronous to `clk`. Only `nmi_pin` may change at arbitrary times. The bench drives every input at the falling edge and waits for each acknowledge before it starts the next access, so these conditions always hold. Random source patterns are dropped to zero before any pending clear, so the bench model can treat pending as a sticky OR of the patterns applied.

// File: rtl/wic_pkg.sv
package wic_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_BASE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EN     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_RESP   = 8'h60;

endpackage

// File: rtl/wic_nmi_trig.sv
module wic_nmi_trig
    import wic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin,
    input  trig_e mode,
    output logic  hit,
    output logic  level_mode
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             cur;
    logic             prev;

    // Synchronizer stages followed by one history flop for edge detection
    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign cur  = chain_q[SYNC_STAGES-1];
    assign prev = chain_q[SYNC_STAGES];

    always_comb begin
        hit        = 1'b0;
        level_mode = 1'b0;
        unique case (mode)
            TRIG_LOW:  begin hit = !cur;          level_mode = 1'b1; end
            TRIG_FALL: begin hit = prev && !cur;  level_mode = 1'b0; end
            TRIG_HIGH: begin hit = cur;           level_mode = 1'b1; end
            TRIG_RISE: begin hit = cur && !prev;  level_mode = 1'b0; end
            default:   begin hit = 1'b0;          level_mode = 1'b0; end
        endcase
    end

endmodule

// File: rtl/wic_bus_fsm.sv
module wic_bus_fsm
    import wic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic ack
);
    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_d = BUS_ACK;   // accept
            BUS_ACK:  state_d = BUS_IDLE;           // release
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept = 1'b0;
        ack    = 1'b0;
        unique case (state_q)
            BUS_IDLE: accept = req;
            BUS_ACK:  ack    = 1'b1;
            default:  begin accept = 1'b0; ack = 1'b0; end
        endcase
    end

endmodule

// File: rtl/wic_low_enc.sv
module wic_low_enc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/aon_wake_intc.sv
module aon_wake_intc
    import wic_pkg::*;
#(
    parameter int N_IRQ       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic              nmi_pin,
    input  logic [N_IRQ-1:1]  irq_src,
    output logic              nmi_req,
    output logic              cpu_irq
);
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic              accept;
    logic              wr_en;
    logic [DATA_W-3:0] base_q;
    trig_e             trig_q;
    logic [N_IRQ-1:0]  pend_q;
    logic [N_IRQ-1:0]  en_q;
    logic [N_IRQ-1:0]  mask_q;
    logic [N_IRQ-1:0]  resp_q;
    logic [N_IRQ-1:0]  pend_d;
    logic [N_IRQ-1:0]  set_vec;
    logic [N_IRQ-1:0]  clr_vec;
    logic [N_IRQ-1:0]  lvl_vec;
    logic              nmi_hit;
    logic              nmi_level;
    logic              vec_found;
    logic [IDX_W-1:0]  vec_idx;
    logic [DATA_W-1:0] vec_word;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    function automatic logic [DATA_W-1:0] widen(input logic [N_IRQ-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[N_IRQ-1:0] = v;
        return r;
    endfunction

    wic_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .accept (accept),
        .ack    (bus_ack)
    );

    wic_nmi_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (nmi_pin),
        .mode       (trig_q),
        .hit        (nmi_hit),
        .level_mode (nmi_level)
    );

    wic_low_enc #(.WIDTH(N_IRQ)) u_enc (
        .vec   (pend_q & ~mask_q),
        .found (vec_found),
        .idx   (vec_idx)
    );

    assign wr_en = accept && bus_we;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            trig_q <= TRIG_RISE;
            en_q   <= '0;
            mask_q <= '0;
            resp_q <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFS_BASE: base_q <= bus_wdata[DATA_W-1:2];
                OFS_TRIG: trig_q <= trig_e'(bus_wdata[1:0]);
                OFS_EN:   en_q   <= bus_wdata[N_IRQ-1:0];
                OFS_MASK: mask_q <= bus_wdata[N_IRQ-1:0];
                OFS_RESP: resp_q <= bus_wdata[N_IRQ-1:0];
                default:  ;
            endcase
        end
    end

    // Pending: clear beats a level set, an edge set survives a clear
    always_comb begin
        set_vec    = '0;
        set_vec[0] = nmi_hit;
        set_vec[N_IRQ-1:1] = irq_src;
        lvl_vec    = '1;
        lvl_vec[0] = nmi_level;
        clr_vec    = (wr_en && bus_addr == OFS_PEND) ? bus_wdata[N_IRQ-1:0] : '0;
        pend_d     = (pend_q & ~clr_vec) | (set_vec & ~(clr_vec & lvl_vec));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign vec_word = {base_q, 2'b00} + (vec_found ? (DATA_W'(vec_idx) << 2) : '0);

    always_comb begin
        unique case (bus_addr)
            OFS_VECTOR: rd_mux = vec_word;
            OFS_BASE:   rd_mux = {base_q, 2'b00};
            OFS_TRIG:   rd_mux = {30'd0, trig_q};
            OFS_PEND:   rd_mux = widen(pend_q);
            OFS_EN:     rd_mux = widen(en_q);
            OFS_MASK:   rd_mux = widen(mask_q);
            OFS_RESP:   rd_mux = widen(resp_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= bus_we ? '0 : rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign nmi_req   = pend_q[0] & en_q[0];
    assign cpu_irq   = |(pend_q & ~mask_q & ~resp_q);

endmodule

// File: rtl/aon_wake_intc_chk.sv
module aon_wake_intc_chk #(
    parameter int N_IRQ = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_ack,
    input logic             nmi_req,
    input logic             cpu_irq,
    input logic [N_IRQ-1:0] pend_q,
    input logic [N_IRQ-1:0] mask_q,
    input logic [N_IRQ-1:0] resp_q,
    input logic [31:0]      vec_word
);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_req));

    a_r5_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] |-> !nmi_req);

    a_r7_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !cpu_irq);

    a_r7_resp_all: assert property (@(posedge clk) disable iff (!rst_n)
        (&resp_q) |-> !cpu_irq);

    a_r7_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !cpu_irq);

    a_r8_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        vec_word[1:0] == 2'b00);
endmodule

bind aon_wake_intc aon_wake_intc_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .nmi_req  (nmi_req),
    .cpu_irq  (cpu_irq),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .resp_q   (resp_q),
    .vec_word (vec_word)
);

// File: tb/sim_aon_wake_intc.sv
module sim_aon_wake_intc;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_ack;
    logic         nmi_pin = 1'b0;
    logic [N-1:1] irq_src = '0;
    logic         nmi_req;
    logic         cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    aon_wake_intc #(.N_IRQ(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .nmi_pin(nmi_pin), .irq_src(irq_src),
        .nmi_req(nmi_req), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R2 write ack", {31'd0, bus_ack}, 32'd1);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        chk("R2 read ack", {31'd0, bus_ack}, 32'd1);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_vec(input logic [31:0] base, input logic [31:0] p,
                                            input logic [31:0] m);
        logic [31:0] v;
        v = p & ~m;
        for (int i = 0; i < N; i++) if (v[i]) return base + 32'(i * 4);
        return base;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] base, mp, mk, rs, en, r, w;
        void'($urandom(32'h5EED_0042));
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 nmi_req", {31'd0, nmi_req}, 0);
        chk("R1 cpu_irq", {31'd0, cpu_irq}, 0);
        rd_chk("R1 vector", 8'h00, 0);
        rd_chk("R1 base", 8'h04, 0);
        rd_chk("R1 trig", 8'h0C, 3);
        rd_chk("R1 pend", 8'h10, 0);
        rd_chk("R1 en", 8'h40, 0);
        rd_chk("R1 mask", 8'h50, 0);
        rd_chk("R1 resp", 8'h60, 0);

        // R3 base alignment
        bus_write(8'h04, 32'h2000_0007);
        base = 32'h2000_0004;
        rd_chk("R3 base", 8'h04, base);
        rd_chk("R8 vector empty", 8'h00, base);

        // R9 unimplemented offsets and vector write
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'h1234_5678);
        bus_write(8'h70, 32'hFFFF_FFFF);
        rd_chk("R9 read 0x08", 8'h08, 0);
        rd_chk("R9 read 0x70", 8'h70, 0);
        rd_chk("R9 base kept", 8'h04, base);
        rd_chk("R9 vector kept", 8'h00, base);
        rd_chk("R9 pend kept", 8'h10, 0);
        rd_chk("R9 mask kept", 8'h50, 0);

        // R4/R5 rising edge with enable
        bus_write(8'h40, 32'h1);
        nmi_pin = 1'b1; idle(4);
        chk("R5 nmi_req rise", {31'd0, nmi_req}, 1);
        rd_chk("R4 rise pend", 8'h10, 1);
        bus_write(8'h10, 32'h1);
        idle(2);
        rd_chk("R6 edge clear held pin", 8'h10, 0);
        chk("R5 nmi_req cleared", {31'd0, nmi_req}, 0);
        nmi_pin = 1'b0; idle(4);

        // R7 enable has no effect on cpu_irq
        bus_write(8'h40, 32'h0);
        nmi_pin = 1'b1; idle(4);
        chk("R5 nmi_req disabled", {31'd0, nmi_req}, 0);
        chk("R7 cpu_irq ignores enable", {31'd0, cpu_irq}, 1);
        nmi_pin = 1'b0; idle(4);
        bus_write(8'h10, 32'h1);

        // R4/R6 high level re-asserts after clear
        bus_write(8'h0C, 32'h2);
        nmi_pin = 1'b1; idle(4);
        rd_chk("R4 high pend", 8'h10, 1);
        bus_write(8'h10, 32'h1);
        rd_chk("R6 level reassert", 8'h10, 1);
        nmi_pin = 1'b0; idle(4);
        bus_write(8'h10, 32'h1);
        rd_chk("R6 level cleared", 8'h10, 0);

        // R4 falling edge
        bus_write(8'h0C, 32'h1);
        nmi_pin = 1'b1; idle(4);
        rd_chk("R4 fall no set on rise", 8'h10, 0);
        nmi_pin = 1'b0; idle(4);
        rd_chk("R4 fall pend", 8'h10, 1);
        bus_write(8'h10, 32'h1);

        // R4 low level
        bus_write(8'h0C, 32'h0);
        idle(2);
        rd_chk("R4 low pend", 8'h10, 1);
        nmi_pin = 1'b1; idle(4);
        bus_write(8'h10, 32'h1);
        rd_chk("R4 low cleared", 8'h10, 0);
        bus_write(8'h0C, 32'h3);
        nmi_pin = 1'b0; idle(4);
        bus_write(8'h10, 32'h1);

        // R6 source held high survives clear
        irq_src[5] = 1'b1; idle(2);
        bus_write(8'h10, 32'h20);
        rd_chk("R6 source reassert", 8'h10, 32'h20);
        irq_src[5] = 1'b0;
        bus_write(8'h10, 32'h20);
        rd_chk("R6 w1c", 8'h10, 0);

        // R7 response blocks, R8 mask steers vector
        irq_src[3] = 1'b1; irq_src[7] = 1'b1; @(negedge clk);
        irq_src = '0;
        bus_write(8'h60, 32'h88);
        chk("R7 resp blocks", {31'd0, cpu_irq}, 0);
        bus_write(8'h60, 32'h08);
        chk("R7 resp release", {31'd0, cpu_irq}, 1);
        bus_write(8'h50, 32'h08);
        rd_chk("R8 vector masked", 8'h00, base + 28);
        bus_write(8'h50, 0); bus_write(8'h60, 0);
        bus_write(8'h10, 32'hFFFF_FFFF);

        // Random phase against a sticky-OR model
        mp = 0;
        for (int it = 0; it < 60; it++) begin
            r  = $urandom() & 32'hFFFF_FFFE & (($urandom() & 1) ? 32'hFFFF_FFFF : 32'h0000_0F0E);
            mk = $urandom() & $urandom();
            rs = $urandom() & $urandom() & $urandom();
            en = $urandom();
            irq_src = r[N-1:1];
            @(negedge clk);
            irq_src = '0;
            mp = mp | r;
            bus_write(8'h50, mk);
            bus_write(8'h60, rs);
            bus_write(8'h40, en);
            chk("R7 cpu_irq random", {31'd0, cpu_irq}, {31'd0, |(mp & ~mk & ~rs)});
            chk("R5 nmi_req random", {31'd0, nmi_req}, 0);
            rd_chk("R8 vector random", 8'h00, exp_vec(base, mp, mk));
            if (it % 4 == 3) begin
                rd_chk("R6 pend random", 8'h10, mp);
                w = $urandom();
                bus_write(8'h10, w);
                mp = mp & ~w;
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule